// File: doc/BRIEF.md
# Receive Frame Buffer with Short-Error Erasure

This block sits between an Ethernet receive MAC and the switching logic behind it. The MAC hands over one byte per cycle with start-of-frame and end-of-frame markers. With the end marker it also gives three flags: an error flag, a pause-frame flag and a MAC-control flag. Bytes go into a 256-entry circular store. A frame becomes visible downstream only once its last byte is written. The downstream side then reads it byte by byte through a valid/ready handshake that carries a last-byte marker and a bad flag.

An errored frame shorter than the runt limit (64 bytes) is rewound. The write pointer drops back to the last committed position, so the frame leaves no trace and its space is free again. A longer errored frame is kept and flagged bad on its last byte, and the downstream logic drops it. If the store fills while a frame is arriving, a configuration bit picks what happens. The frame is either discarded or truncated and flagged bad.

The write side is a three-state machine:
- **IDLE** waits for a start byte. It goes to **RECV** when the start byte is accepted, or to **DROP** when receive is disabled and the start byte does not also end the frame. It stays in **IDLE** for a frame that is accepted or dropped within a single byte.
- **RECV** returns to **IDLE** on the end byte, whether the frame is committed or erased. It goes to **DROP** on an overrun.
- **DROP** discards bytes until the end byte and then returns to **IDLE**.

Top module: `rxf_frame_fifo`

## Requirements
- R1: The buffer holds at most DEPTH (256) bytes. A good frame of exactly 256 bytes arriving into an empty buffer is stored and delivered whole.
- R2: Good frames come out in arrival order with identical bytes. out_last is high on the final byte and out_bad is low.
- R3: A frame whose end byte carries in_err and whose length is below RUNT_LEN (64) produces no output, and all of its space is reclaimed.
- R4: A frame whose end byte carries in_err and whose length is RUNT_LEN or more is delivered whole, with out_bad high on its last byte only.
- R5: With cfg_ovf_discard=1, a frame that finds the buffer full before its end byte is removed completely. The rest of that frame is ignored, and frames before and after it are unaffected.
- R6: With cfg_ovf_discard=0, a frame that reaches the last free entry before its end byte is cut there. That byte is stored as the last byte with out_bad high. If the cut frame would be shorter than RUNT_LEN, it is erased as in R3.
- R7: A frame whose end byte carries in_pause is never delivered, whatever the other configuration bits are.
- R8: A frame whose end byte carries in_ctl (and not in_pause) is delivered when cfg_ctl_fwd=1 and erased when cfg_ctl_fwd=0.
- R9: cfg_rx_en is sampled only on a start byte. A frame starting while it is 0 is ignored entirely. Changing it in mid-frame does not change the fate of that frame.
- R10: While out_valid is high and out_ready low, out_valid, out_data, out_last and out_bad hold. A byte is consumed only on a cycle where both are high.
- R11: After reset, out_valid is low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_en | input | 1 | Receive enable, sampled on start byte |
| cfg_ovf_discard | input | 1 | 1: discard frame on overrun; 0: truncate and flag bad |
| cfg_ctl_fwd | input | 1 | 1: forward non-pause MAC control frames |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error, qualified by in_eof |
| in_pause | input | 1 | Pause frame, qualified by in_eof |
| in_ctl | input | 1 | MAC control frame, qualified by in_eof |
| out_ready | input | 1 | Downstream accepts byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of frame |
| out_bad | output | 1 | Frame bad, valid with out_last |

## Verification
The bench sweeps errored frame lengths 1 to 63 back to back with downstream stalled, then sends a full 256-byte good frame. A design that failed to reclaim runt space would lose that frame, and one with an off-by-one at the limit would leak a 63-byte frame or erase a 64-byte one. The overrun cases are set up so that the cut lands exactly on the last free entry: once above the runt limit, where a 246-byte bad frame is expected, and once below it, where the frame must vanish. A pointer rewound to the wrong place would corrupt the frame stored before it. Pause, control and enable cases check that filtering and mid-frame enable changes neither leak partial frames nor drop the next frame. Stalled reads check that data holds under backpressure.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RECV = 2'd1,
        WS_DROP = 2'd2
    } wr_state_t;

    typedef struct packed {
        logic              bad;
        logic              last;
        logic [BYTE_W-1:0] data;
    } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  rxf_entry_t    wr_entry,
    input  logic [AW-1:0] rd_addr,
    output rxf_entry_t    rd_entry
);
    rxf_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_entry;
    end

    assign rd_entry = mem[rd_addr];
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int RUNT_LEN = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              cfg_ovf_discard,
    input  logic              cfg_ctl_fwd,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic              in_pause,
    input  logic              in_ctl,
    input  logic [PW-1:0]     rd_ptr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output rxf_entry_t        wr_entry,
    output logic [PW-1:0]     commit_ptr
);
    wr_state_t     state, nxt;
    logic [PW-1:0] wptr, cptr, len;
    logic [PW-1:0] used, len_n;
    logic          has_room, last_slot, start, beat, reject_eof;
    logic          do_commit, do_flush, ent_last, ent_bad;

    // Occupancy and frame-length bookkeeping for the incoming byte
    always_comb begin
        used       = wptr - rd_ptr;
        has_room   = used < PW'(DEPTH);
        last_slot  = used == PW'(DEPTH - 1);
        start      = (state == WS_IDLE) && in_valid && in_sof && cfg_rx_en;
        beat       = start || ((state == WS_RECV) && in_valid);
        len_n      = (start ? '0 : len) + 1'b1;
        reject_eof = in_pause || (in_ctl && !cfg_ctl_fwd) ||
                     (in_err && (len_n < PW'(RUNT_LEN))) || !has_room;
    end

    // Next state and write/commit/flush decisions
    always_comb begin
        nxt       = state;
        wr_en     = 1'b0;
        do_commit = 1'b0;
        do_flush  = 1'b0;
        ent_last  = 1'b0;
        ent_bad   = 1'b0;
        unique case (state)
            WS_IDLE: if (in_valid && in_sof && !cfg_rx_en && !in_eof) nxt = WS_DROP;
            WS_RECV: ;
            WS_DROP: if (in_valid && in_eof) nxt = WS_IDLE;
            default: nxt = WS_IDLE;
        endcase
        if (beat) begin
            if (in_eof) begin
                nxt = WS_IDLE;
                if (reject_eof) begin
                    do_flush = 1'b1;
                end else begin
                    wr_en     = 1'b1;
                    ent_last  = 1'b1;
                    ent_bad   = in_err;
                    do_commit = 1'b1;
                end
            end else if (!has_room) begin
                do_flush = 1'b1;
                nxt      = WS_DROP;
            end else if (!cfg_ovf_discard && last_slot) begin
                nxt = WS_DROP;
                if (len_n < PW'(RUNT_LEN)) begin
                    do_flush = 1'b1;
                end else begin
                    wr_en     = 1'b1;
                    ent_last  = 1'b1;
                    ent_bad   = 1'b1;
                    do_commit = 1'b1;
                end
            end else begin
                wr_en = 1'b1;
                nxt   = WS_RECV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WS_IDLE;
            wptr  <= '0;
            cptr  <= '0;
            len   <= '0;
        end else begin
            state <= nxt;
            if (do_flush)   wptr <= cptr;
            else if (wr_en) wptr <= wptr + 1'b1;
            if (do_commit)  cptr <= wptr + 1'b1;
            if (beat)       len  <= len_n;
        end
    end

    assign wr_addr    = wptr[AW-1:0];
    assign wr_entry   = '{bad: ent_bad, last: ent_last, data: in_data};
    assign commit_ptr = cptr;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rd_ptr) <= PW'(DEPTH)); // R1
    AST_IDLE_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_IDLE) |-> (wptr == cptr)); // R9
    AST_DROP_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_DROP) |-> (wptr == cptr)); // R5
    AST_RUNT_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && in_eof && in_err && (len_n < PW'(RUNT_LEN)))
        |=> (wptr == cptr) && $stable(cptr)); // R3
    AST_PAUSE_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && in_eof && in_pause) |=> $stable(cptr)); // R7
endmodule

// File: rtl/rxf_rd_port.sv
module rxf_rd_port
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     commit_ptr,
    input  rxf_entry_t        rd_entry,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              out_bad,
    output logic [PW-1:0]     rd_ptr,
    output logic [AW-1:0]     rd_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_ptr <= '0;
        else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
    end

    assign out_valid = rd_ptr != commit_ptr;
    assign rd_addr   = rd_ptr[AW-1:0];
    assign out_data  = rd_entry.data;
    assign out_last  = rd_entry.last;
    assign out_bad   = rd_entry.bad;

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
        $stable(out_last) && $stable(out_bad)); // R10
    AST_BAD_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bad) |-> out_last); // R4
    AST_CONSUME_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> $stable(rd_ptr)); // R10
endmodule

// File: rtl/rxf_frame_fifo.sv
module rxf_frame_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int RUNT_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_rx_en,
    input  logic       cfg_ovf_discard,
    input  logic       cfg_ctl_fwd,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_err,
    input  logic       in_pause,
    input  logic       in_ctl,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_bad
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] commit_ptr, rd_ptr;
    rxf_entry_t    wr_entry, rd_entry;

    rxf_wr_ctrl #(.DEPTH(DEPTH), .RUNT_LEN(RUNT_LEN)) u_wr (
        .clk, .rst_n, .cfg_rx_en, .cfg_ovf_discard, .cfg_ctl_fwd,
        .in_valid, .in_data, .in_sof, .in_eof, .in_err, .in_pause, .in_ctl,
        .rd_ptr, .wr_en, .wr_addr, .wr_entry, .commit_ptr
    );

    rxf_store #(.DEPTH(DEPTH)) u_mem (
        .clk, .wr_en, .wr_addr, .wr_entry, .rd_addr, .rd_entry
    );

    rxf_rd_port #(.DEPTH(DEPTH)) u_rd (
        .clk, .rst_n, .commit_ptr, .rd_entry, .out_ready,
        .out_valid, .out_data, .out_last, .out_bad, .rd_ptr, .rd_addr
    );

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R11
endmodule

// File: tb/sim_rxf_frame_fifo.sv
module sim_rxf_frame_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rx_en = 1'b1, cfg_ovf_discard = 1'b1, cfg_ctl_fwd = 1'b1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic in_err = 1'b0, in_pause = 1'b0, in_ctl = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_ready = 1'b0;
    logic out_valid, out_last, out_bad;
    logic [7:0] out_data;

    int checks = 0, errors = 0;
    int exp_len[$], exp_seed[$];
    bit exp_bad[$];
    string exp_tag[$];

    always #10 clk = ~clk;

    rxf_frame_fifo u0 (
        .clk, .rst_n, .cfg_rx_en, .cfg_ovf_discard, .cfg_ctl_fwd,
        .in_valid, .in_data, .in_sof, .in_eof, .in_err, .in_pause, .in_ctl,
        .out_ready, .out_valid, .out_data, .out_last, .out_bad
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_frame(input int len, input int seed, input bit bad,
                                input string tag);
        exp_len.push_back(len);
        exp_seed.push_back(seed);
        exp_bad.push_back(bad);
        exp_tag.push_back(tag);
    endtask

    task automatic send(input int len, input bit err, input bit pause,
                        input bit ctl, input int seed, input int flip_at);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_err   = (i == len - 1) && err;
            in_pause = (i == len - 1) && pause;
            in_ctl   = (i == len - 1) && ctl;
            in_data  = 8'((seed + i) & 255);
            if (i == flip_at) cfg_rx_en = !cfg_rx_en;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_err = 1'b0; in_pause = 1'b0; in_ctl = 1'b0;
    endtask

    task automatic check_frame(input logic [7:0] got[$], input bit bad);
        int len, seed, mism;
        bit eb;
        string tag;
        if (exp_len.size() == 0) begin
            chk(1'b0, "R2", "unexpected frame length", got.size(), 0);
            return;
        end
        len = exp_len.pop_front(); seed = exp_seed.pop_front();
        eb = exp_bad.pop_front(); tag = exp_tag.pop_front();
        chk(got.size() == len, tag, "frame length", got.size(), len);
        mism = 0;
        for (int i = 0; i < got.size(); i++)
            if (got[i] != 8'((seed + i) & 255)) mism++;
        chk(mism == 0, tag, "mismatching bytes", mism, 0);
        chk(bad == eb, tag, "bad flag on last byte", bad, eb);
    endtask

    task automatic drain(input bit toggle, input string tag);
        logic [7:0] got[$];
        int idle = 0;
        int cyc = 0;
        bit rdy;
        bit nonlast_bad = 0;
        while (idle < 5) begin
            @(negedge clk);
            rdy = toggle ? cyc[0] : 1'b1;
            cyc++;
            out_ready = rdy;
            if (out_valid && rdy) begin
                got.push_back(out_data);
                if (!out_last && out_bad) nonlast_bad = 1;
                if (out_last) begin
                    check_frame(got, out_bad);
                    got.delete();
                end
            end
            if (!out_valid) idle++; else idle = 0;
        end
        out_ready = 1'b0;
        chk(got.size() == 0, tag, "trailing bytes without last", got.size(), 0);
        chk(!nonlast_bad, "R4", "bad flag on a non-last byte", nonlast_bad, 0);
        chk(exp_len.size() == 0, tag, "expected frames not delivered", exp_len.size(), 0);
        exp_len.delete(); exp_seed.delete(); exp_bad.delete(); exp_tag.delete();
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);

        // R2: good frames of several lengths, stalled then drained
        send(1, 0, 0, 0, 3, -1);    expect_frame(1, 3, 0, "R2");
        send(2, 0, 0, 0, 17, -1);   expect_frame(2, 17, 0, "R2");
        send(60, 0, 0, 0, 40, -1);  expect_frame(60, 40, 0, "R2");
        send(64, 0, 0, 0, 90, -1);  expect_frame(64, 90, 0, "R2");
        send(100, 0, 0, 0, 200, -1); expect_frame(100, 200, 0, "R2");
        drain(0, "R2");

        // R10: stalled output holds
        send(3, 0, 0, 0, 77, -1);
        @(negedge clk); d0 = out_data;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b1, "R10", "valid held under stall", out_valid, 1);
        chk(out_data == d0, "R10", "data held under stall", out_data, d0);
        expect_frame(3, 77, 0, "R10");
        drain(1, "R10");

        // R3: every runt error length erased, space reclaimed; R1: full frame fits
        for (int l = 1; l < 64; l++) send(l, 1, 0, 0, l, -1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3", "runt error frames produced output", out_valid, 0);
        send(256, 0, 0, 0, 9, -1); expect_frame(256, 9, 0, "R1");
        drain(1, "R1");

        // R4: error frames at and above the runt limit kept and marked bad
        for (int l = 64; l < 72; l++) begin
            send(l, 1, 0, 0, l * 3, -1); expect_frame(l, l * 3, 1, "R4");
            drain(0, "R4");
        end
        send(200, 1, 0, 0, 5, -1); expect_frame(200, 5, 1, "R4");
        drain(0, "R4");

        // R5: overrun in discard mode
        cfg_ovf_discard = 1'b1;
        send(10, 0, 0, 0, 11, -1);  expect_frame(10, 11, 0, "R5");
        send(300, 0, 0, 0, 50, -1);
        send(20, 0, 0, 0, 60, -1);  expect_frame(20, 60, 0, "R5");
        drain(0, "R5");

        // R6: overrun in mark mode, cut above and below the runt limit
        cfg_ovf_discard = 1'b0;
        send(10, 0, 0, 0, 11, -1);  expect_frame(10, 11, 0, "R6");
        send(300, 0, 0, 0, 50, -1); expect_frame(246, 50, 1, "R6");
        drain(0, "R6");
        send(200, 0, 0, 0, 70, -1); expect_frame(200, 70, 0, "R6");
        send(100, 0, 0, 0, 80, -1);
        drain(0, "R6");
        cfg_ovf_discard = 1'b1;

        // R7 and R8: pause and control filtering
        cfg_ctl_fwd = 1'b1;
        send(64, 0, 1, 0, 1, -1);
        send(64, 0, 1, 1, 2, -1);
        send(64, 0, 0, 1, 3, -1);   expect_frame(64, 3, 0, "R8");
        cfg_ctl_fwd = 1'b0;
        send(64, 0, 1, 0, 4, -1);
        send(64, 0, 0, 1, 5, -1);
        send(30, 0, 0, 0, 6, -1);   expect_frame(30, 6, 0, "R7");
        drain(0, "R7");
        cfg_ctl_fwd = 1'b1;

        // R9: receive enable sampled at the start byte only
        cfg_rx_en = 1'b0;
        send(80, 0, 0, 0, 7, -1);
        send(80, 0, 0, 0, 8, 5);
        cfg_rx_en = 1'b1;
        send(70, 0, 0, 0, 9, 5);    expect_frame(70, 9, 0, "R9");
        cfg_rx_en = 1'b1;
        send(12, 0, 0, 0, 10, -1);  expect_frame(12, 10, 0, "R9");
        drain(0, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule